// File: doc/BRIEF.md
# Paged Filter Coefficient Register File

This block is the register-side home of a 120-tap filter coefficient bank. Software reaches it through already-deserialised 16-bit command words. Each command word carries three fields: a direction flag, a 7-bit byte address and one data byte. A 16-bit page select register decides which block of registers the byte address refers to. Two consecutive pages together hold the whole coefficient bank. The first of these pages holds the lower half of the taps, and the second holds the upper half. On both pages the taps sit in the same byte window.

Each coefficient is a signed 16-bit value, written one byte at a time. A read command returns the whole 16-bit word that contains the addressed byte, in the cycle after the command. A separate combinational port lets the filter datapath fetch any coefficient by its tap number, independently of the command traffic.

Top module: `paged_coef_regs`

## Requirements
- R1: After reset the page select register holds 0x0000, so a read of byte address 0x00 returns 0x0000.
- R2: A write to byte address 0x00 sets bits 7:0 of the page select register, and a write to 0x01 sets bits 15:8. This works on every page. For example, command 0x8002 selects page 2.
- R3: A read of byte address 0x00 or 0x01 returns the full 16-bit page select value.
- R4: On page 5, tap k (0 to 59) sits at byte addresses 0x08+2k and 0x09+2k. On page 6, tap 60+k sits at the same addresses. For example, tap 71 is at page 6, addresses 0x1E and 0x1F.
- R5: The even byte address of a tap holds bits 7:0 and the odd address holds bits 15:8. A byte write leaves the other byte of that tap unchanged. For example, writing 0x57 then 0xFF to tap 71 stores 0xFF57, which is -169.
- R6: A read of either byte address of a tap returns that tap's full 16-bit word.
- R7: All other addresses are unused. These are 0x02 to 0x07 on pages 5 and 6, and every address from 0x02 up on any other page. A read of an unused address returns 0x0000. A write to one changes neither a coefficient nor the page register.
- R8: The coefficient port returns the stored word of tap `tap_idx` in the same cycle. For an index of 120 or more it returns 0x0000.
- R9: Command word bit 15 = 1 marks a write and 0 marks a read. Bits 14:8 are the byte address and bits 7:0 the write data. `rsp_valid` is high exactly in the cycle after an accepted read, and low after a write or an idle cycle.
- R10: After reset every coefficient reads as 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word present this cycle |
| cmd_word | input | 16 | Decoded command: write flag, byte address, data byte |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Word containing the byte addressed by the preceding read |
| tap_idx | input | 7 | Tap number for the datapath coefficient port |
| tap_coef | output | 16 | Signed coefficient of tap `tap_idx` |

## Verification
The hardest case to reach is a correct tap index that depends on the page and on the byte address together. A wrong offset at the seam between the two coefficient pages looks fine on each page alone.

The random stimulus therefore keeps the page register on pages 5 and 6 most of the time and switches it often through byte writes to the page register. Directed writes hit the first and last byte of both windows, so the taps on either side of the seam are checked together. After every command a random read of the datapath port cross-checks the whole bank.

// File: rtl/pcr_pkg.sv
// Shared widths and types for the paged coefficient register file.
// Assumes command words are already parallel: {write flag, 7-bit byte address, data byte}.
package pcr_pkg;
    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_PAGE = 2'd1,
        TGT_COEF = 2'd2
    } pcr_tgt_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [BYTE_W-1:0] data;
    } pcr_cmd_t;
endpackage

// File: rtl/pcr_addr_map.sv
// Decodes (page, byte address) into a target: the page register, one byte of one tap, or nothing.
// Assumes the page register sits at byte addresses 0 and 1 on every page and that the
// coefficient pages are consecutive, starting at FIRST_PAGE.
module pcr_addr_map
    import pcr_pkg::*;
#(
    parameter int NUM_TAPS      = 120,
    parameter int TAPS_PER_PAGE = 60,
    parameter int FIRST_PAGE    = 5,
    parameter int WIN_BASE      = 8,
    parameter int IDX_W         = $clog2(NUM_TAPS)
) (
    input  logic [WORD_W-1:0] page,
    input  logic [ADDR_W-1:0] addr,
    output pcr_tgt_e          tgt,
    output logic [IDX_W-1:0]  idx,
    output logic              hi_byte
);
    localparam int NUM_PAGES = (NUM_TAPS + TAPS_PER_PAGE - 1) / TAPS_PER_PAGE;

    int unsigned slot;
    int unsigned pg_off;
    int unsigned flat;

    // Classify the access and compute the tap number from the page offset and the window slot.
    always_comb begin
        slot    = (int'(addr) >= WIN_BASE) ? (int'(addr) - WIN_BASE) / 2 : 0;
        pg_off  = int'(page) - FIRST_PAGE;
        flat    = pg_off * TAPS_PER_PAGE + slot;
        tgt     = TGT_NONE;
        idx     = '0;
        hi_byte = addr[0];
        if (addr[ADDR_W-1:1] == '0) begin
            tgt = TGT_PAGE;
        end else if (int'(page) >= FIRST_PAGE && int'(page) < FIRST_PAGE + NUM_PAGES &&
                     int'(addr) >= WIN_BASE && slot < TAPS_PER_PAGE && flat < NUM_TAPS) begin
            tgt = TGT_COEF;
            idx = IDX_W'(flat);
        end
    end
endmodule

// File: rtl/pcr_page_reg.sv
// The 16-bit page select register, written one byte at a time.
// Assumes at most one byte write per cycle.
module pcr_page_reg
    import pcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [WORD_W-1:0] page_q
);
    // Update the selected byte lane; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (wr_en) begin
            if (wr_hi) page_q[WORD_W-1:BYTE_W] <= wr_data;
            else       page_q[BYTE_W-1:0]      <= wr_data;
        end
    end
endmodule

// File: rtl/pcr_coef_bank.sv
// Coefficient storage: NUM_TAPS words with byte-lane writes and two combinational read ports.
// Assumes the writer supplies an in-range index; out-of-range read indices return zero.
module pcr_coef_bank
    import pcr_pkg::*;
#(
    parameter int NUM_TAPS = 120,
    parameter int IDX_W    = $clog2(NUM_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_a_idx,
    output logic [WORD_W-1:0] rd_a_word,
    input  logic [IDX_W-1:0]  rd_b_idx,
    output logic [WORD_W-1:0] rd_b_word
);
    logic [NUM_TAPS*WORD_W-1:0] words_flat;

    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        logic [WORD_W-1:0] word_q;
        logic              hit;

        assign hit = wr_en && (int'(wr_idx) == g);

        // Store one byte lane of this tap on a matching write; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (hit) begin
                if (wr_hi) word_q[WORD_W-1:BYTE_W] <= wr_data;
                else       word_q[BYTE_W-1:0]      <= wr_data;
            end
        end

        assign words_flat[g*WORD_W +: WORD_W] = word_q;
    end

    // Port A serves the command response path, with zero for an out-of-range index.
    always_comb begin
        rd_a_word = '0;
        if (int'(rd_a_idx) < NUM_TAPS) rd_a_word = words_flat[int'(rd_a_idx)*WORD_W +: WORD_W];
    end

    // Port B serves the filter datapath, with zero for an out-of-range index.
    always_comb begin
        rd_b_word = '0;
        if (int'(rd_b_idx) < NUM_TAPS) rd_b_word = words_flat[int'(rd_b_idx)*WORD_W +: WORD_W];
    end
endmodule

// File: rtl/paged_coef_regs.sv
// Paged register file holding the page select register and a two-page coefficient bank.
// Assumes one command per cycle at most; a read is answered in the following cycle.
module paged_coef_regs
    import pcr_pkg::*;
#(
    parameter int NUM_TAPS      = 120,
    parameter int TAPS_PER_PAGE = 60,
    parameter int FIRST_PAGE    = 5,
    parameter int WIN_BASE      = 8,
    parameter int IDX_W         = $clog2(NUM_TAPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [15:0]       cmd_word,
    output logic              rsp_valid,
    output logic [15:0]       rsp_data,
    input  logic [IDX_W-1:0]  tap_idx,
    output logic [15:0]       tap_coef
);
    pcr_cmd_t          cmd;
    pcr_tgt_e          tgt;
    logic [IDX_W-1:0]  cmd_idx;
    logic              cmd_hi;
    logic [WORD_W-1:0] page_q;
    logic [WORD_W-1:0] coef_word;
    logic              page_wr;
    logic              coef_wr;
    logic              rd_req;

    assign cmd     = pcr_cmd_t'(cmd_word);
    assign page_wr = cmd_valid && cmd.wr && (tgt == TGT_PAGE);
    assign coef_wr = cmd_valid && cmd.wr && (tgt == TGT_COEF);
    assign rd_req  = cmd_valid && !cmd.wr;

    pcr_addr_map #(
        .NUM_TAPS(NUM_TAPS), .TAPS_PER_PAGE(TAPS_PER_PAGE),
        .FIRST_PAGE(FIRST_PAGE), .WIN_BASE(WIN_BASE), .IDX_W(IDX_W)
    ) u_map (
        .page(page_q), .addr(cmd.addr), .tgt(tgt), .idx(cmd_idx), .hi_byte(cmd_hi)
    );

    pcr_page_reg u_page (
        .clk(clk), .rst_n(rst_n), .wr_en(page_wr), .wr_hi(cmd_hi),
        .wr_data(cmd.data), .page_q(page_q)
    );

    pcr_coef_bank #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(coef_wr), .wr_idx(cmd_idx), .wr_hi(cmd_hi),
        .wr_data(cmd.data), .rd_a_idx(cmd_idx), .rd_a_word(coef_word),
        .rd_b_idx(tap_idx), .rd_b_word(tap_coef)
    );

    // Register the read response: the full word behind the addressed byte, zero if unused.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= rd_req;
            if (rd_req) begin
                case (tgt)
                    TGT_PAGE: rsp_data <= page_q;
                    TGT_COEF: rsp_data <= coef_word;
                    default:  rsp_data <= '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/pcr_checker.sv
// Protocol and register properties of paged_coef_regs, bound to every instance.
module pcr_checker #(
    parameter int NUM_TAPS = 120,
    parameter int IDX_W    = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [15:0]      cmd_word,
    input logic             rsp_valid,
    input logic [15:0]      rsp_data,
    input logic [IDX_W-1:0] tap_idx,
    input logic [15:0]      tap_coef,
    input logic [15:0]      page_q
);
    // R9: a read is answered in the next cycle
    assert_read_answered_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_word[15] |=> rsp_valid);

    // R9: no response without a read
    assert_no_spurious_rsp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && !cmd_word[15]) |=> !rsp_valid);

    // R2: a write to byte 0 lands in the low byte of the page register
    assert_page_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_word[15] && cmd_word[14:8] == 7'h00 |=> page_q[7:0] == $past(cmd_word[7:0]));

    // R2: a write to byte 1 lands in the high byte of the page register
    assert_page_high_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_word[15] && cmd_word[14:8] == 7'h01 |=> page_q[15:8] == $past(cmd_word[7:0]));

    // R3: reading the page register returns its full value
    assert_page_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_word[15] && cmd_word[14:9] == 6'h00 |=> rsp_data == $past(page_q));

    // R7: writes above byte 1 never touch the page register
    assert_page_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_word[15] && cmd_word[14:9] != 6'h00 |=> $stable(page_q));

    // R7: unused bytes on a coefficient page read as zero
    assert_unused_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_word[15] && (page_q == 16'd5 || page_q == 16'd6) &&
        cmd_word[14:8] >= 7'h02 && cmd_word[14:8] <= 7'h07 |=> rsp_data == 16'h0000);

    // R8: an index beyond the bank yields zero
    assert_tap_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_idx) >= NUM_TAPS |-> tap_coef == 16'h0000);
endmodule

bind paged_coef_regs pcr_checker #(.NUM_TAPS(NUM_TAPS), .IDX_W(IDX_W)) u_pcr_checker (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tap_idx(tap_idx),
    .tap_coef(tap_coef), .page_q(page_q)
);

// File: tb/sim_paged_coef_regs.sv
module sim_paged_coef_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        rsp_valid;
    logic [15:0] rsp_data;
    logic [6:0]  tap_idx = '0;
    logic [15:0] tap_coef;

    int n_checks = 0;
    int n_errors = 0;

    logic [15:0] m_page;
    logic [15:0] m_coef [120];

    always #4 clk = ~clk;

    paged_coef_regs u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .tap_idx(tap_idx), .tap_coef(tap_coef)
    );

    // Tap number for (page, address), or -1 when the address is not a coefficient byte.
    function automatic int tap_of(logic [15:0] pg, logic [6:0] a);
        if (a < 7'h08) return -1;
        if (pg == 16'd5) return (int'(a) - 8) / 2;
        if (pg == 16'd6) return 60 + (int'(a) - 8) / 2;
        return -1;
    endfunction

    function automatic logic [15:0] exp_read(logic [6:0] a);
        int t;
        if (a < 7'h02) return m_page;
        t = tap_of(m_page, a);
        if (t < 0) return 16'h0000;
        return m_coef[t];
    endfunction

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [6:0] a, logic [7:0] d);
        int t;
        if (a == 7'h00) m_page[7:0] = d;
        else if (a == 7'h01) m_page[15:8] = d;
        else begin
            t = tap_of(m_page, a);
            if (t >= 0) begin
                if (a[0]) m_coef[t][15:8] = d;
                else      m_coef[t][7:0]  = d;
            end
        end
    endtask

    task automatic do_write(logic [6:0] a, logic [7:0] d);
        cmd_valid = 1'b1;
        cmd_word  = {1'b1, a, d};
        @(negedge clk);
        cmd_valid = 1'b0;
        model_write(a, d);
        check("R9 no response after write", {15'd0, rsp_valid}, 16'd0);
    endtask

    task automatic do_read(string req, logic [6:0] a);
        logic [15:0] e;
        e = exp_read(a);
        cmd_valid = 1'b1;
        cmd_word  = {1'b0, a, 8'h00};
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R9 response valid", {15'd0, rsp_valid}, 16'd1);
        check(req, rsp_data, e);
    endtask

    task automatic check_tap(string req, int t);
        tap_idx = 7'(t);
        #1;
        check(req, tap_coef, (t < 120) ? m_coef[t] : 16'h0000);
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_page = '0;
        for (int i = 0; i < 120; i++) m_coef[i] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state: R1, R10, R9
        check("R9 idle after reset", {15'd0, rsp_valid}, 16'd0);
        do_read("R1 page after reset", 7'h00);
        for (int i = 0; i < 120; i += 17) check_tap("R10 coefficient after reset", i);

        // R2 / R3: 0x8002 selects page 2, high byte via address 1
        do_write(7'h00, 8'h02);
        do_read("R2 page low byte", 7'h00);
        do_write(7'h01, 8'h12);
        do_read("R3 page full word at odd address", 7'h01);
        check("R2 page value", m_page, 16'h1202);
        do_write(7'h20, 8'hAA); // R7 write on a non-coefficient page
        do_read("R7 unused read on other page", 7'h20);
        do_write(7'h01, 8'h00);
        do_write(7'h00, 8'h06);

        // R4 / R5: tap 71 at page 6, 0x1E/0x1F, -169 = 0xFF57
        do_write(7'h1E, 8'h57);
        check_tap("R5 low byte only", 71);
        do_write(7'h1F, 8'hFF);
        check_tap("R4 tap 71 mapping", 71);
        check("R5 tap 71 value", tap_coef, 16'hFF57);
        do_read("R6 read even byte of tap 71", 7'h1E);
        do_read("R6 read odd byte of tap 71", 7'h1F);

        // R4 window edges on both pages
        do_write(7'h08, 8'h60); do_write(7'h09, 8'h06);
        do_write(7'h7E, 8'h19); do_write(7'h7F, 8'h91);
        do_write(7'h00, 8'h05);
        do_write(7'h08, 8'h00); do_write(7'h09, 8'hA0);
        do_write(7'h7E, 8'h59); do_write(7'h7F, 8'h05);
        check_tap("R4 tap 0", 0);
        check_tap("R4 tap 59", 59);
        check_tap("R4 tap 60", 60);
        check_tap("R4 tap 119", 119);

        // R7: unused window bytes on a coefficient page
        for (int a = 2; a < 8; a++) begin
            do_write(7'(a), 8'hC3);
            do_read("R7 unused read on coefficient page", 7'(a));
        end
        check("R7 page kept", m_page, 16'h0005);
        do_read("R7 page register after unused writes", 7'h00);
        for (int i = 0; i < 120; i++) check_tap("R7 bank unchanged", i);

        // R8: out-of-range tap index
        check_tap("R8 index 120", 120);
        check_tap("R8 index 127", 127);

        // Constrained random mix, mostly on the two coefficient pages
        for (int n = 0; n < 3000; n++) begin
            int r;
            logic [6:0] a;
            r = int'($urandom_range(0, 99));
            if (r < 6) begin
                do_write(7'h00, ($urandom_range(0, 9) < 8) ? 8'(5 + $urandom_range(0, 1))
                                                            : 8'($urandom));
                if (m_page[15:8] != 8'h00 && $urandom_range(0, 1) == 1) do_write(7'h01, 8'h00);
            end else begin
                a = 7'($urandom);
                if (r < 55) do_write(a, 8'($urandom));
                else        do_read("R6 random read", a);
            end
            check_tap("R8 random tap", int'($urandom_range(0, 127)));
        end
        for (int i = 0; i < 120; i++) check_tap("R4 final bank", i);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule